// File: doc/BRIEF.md
# Crosspoint Node Serial Configuration Interface

This block is the serial control logic of one 4x4 crosspoint switch node that sits in a daisy-chained array of such nodes. A host shifts 30-bit control words into the serial input one bit per shift-clock rising edge, most significant bit first. Every node passes the bit stream on to its neighbours through a row output and a column output after a fixed pass-through delay, and it rewrites the stream where its own role requires it. The node reads the word header (frame code, row address, column address) and may then store the word, answer it as a read request, or forward it untouched.

A write word addressed to the node's own row and column position goes through a short staging pipeline into a load register. A synchronous load strobe then copies that register into the active configuration, which drives four 3-bit output-select fields. A read word addressed to the node leaves it carrying the node's active configuration in its select fields and the sender column code 6'b111111. Any read word that the node only relays leaves with its column field reduced by one, so the host can tell how many nodes the answer passed through. The shift clock is passed on to the next node unchanged.

A three-state controller tracks word boundaries. The states are HUNT, HEAD and BODY. The transition HUNT to HEAD is taken when a 1 bit arrives, which is the second bit of a frame code. HEAD to BODY is taken when the last column-address bit arrives. The action for the word is decided on that same edge. BODY to HUNT is taken on the last select bit.

Top module: `xpn_node`

## Requirements
- R1: A word is 30 bits, MSB first. The frame code is in 29:24, the row in 23:18, the column in 17:12, and the select fields in 11:0 with OUT1 in 11:9, OUT2 in 8:6, OUT3 in 5:3 and OUT4 in 2:0. A frame code begins 0 then 1. Between words the input idles at 0, and the controller locks onto a word when the first 1 arrives.
- R2: Each input bit appears on rso after exactly 7 sclk rising edges, and cso always equals rso.
- R3: A write word (frame code 6'b011111) whose row and column equal my_row and my_col reaches the load register 2 edges after the edge that samples its last bit. A load strobe sampled on that second edge has no effect. A strobe sampled on the following edge commits the word.
- R4: A load strobe sampled high while a captured word is pending copies it into cfg_sel, and that commit uses up the pending word.
- R5: A load strobe sampled while no captured word is pending leaves cfg_sel unchanged.
- R6: A write word that does not match the node, and a word with any frame code other than write or read, is forwarded unchanged and never captured.
- R7: A read word (frame code 6'b011110) whose row and column match the node is forwarded with column 6'b111111 and with cfg_sel in its select fields. Its other bits are kept.
- R8: A read word that does not match the node is forwarded with its column field decremented by one modulo 64. All other bits stay unchanged.
- R9: After answering a read, the node goes straight back to accepting write words.
- R10: Reset (rst_n low, asynchronous) clears cfg_sel to all zeros, drives rso and cso low, and leaves nothing pending.
- R11: sclk_fwd follows sclk at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Shift clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| si | input | 1 | Serial data input |
| load | input | 1 | Commit strobe, sampled on sclk |
| my_row | input | 6 | Row position of this node |
| my_col | input | 6 | Column position of this node |
| rso | output | 1 | Serial output toward the row neighbour |
| cso | output | 1 | Serial output toward the column neighbour |
| sclk_fwd | output | 1 | Shift clock passed to the next node |
| cfg_sel | output | 12 | Active selects: OUT1 in 11:9 down to OUT4 in 2:0 |

## Verification
The assertions watch the following on every cycle. A 1 during HUNT always opens a header. BODY only ever runs over select-bit positions. A bit taken in while hunting leaves seven edges later unmodified. A staged word always lands as pending. A load strobe with nothing pending never moves the configuration. The bench scenarios cover what only whole words can show: the rewritten column and select fields of answered and relayed read words, the wrap of the column field from zero, the exact edge on which a commit first becomes possible, and the fact that non-matching or foreign-coded words are never captured.

// File: rtl/xpn_pkg.sv
package xpn_pkg;
    localparam int WORD_W   = 30;
    localparam int CODE_W   = 6;
    localparam int ADDR_W   = 6;
    localparam int SEL_W    = 3;
    localparam int NOUT     = 4;
    localparam int CFG_W    = SEL_W * NOUT;
    localparam int COL_LSB  = CFG_W;
    localparam int ROW_LSB  = COL_LSB + ADDR_W;
    localparam int CODE_LSB = ROW_LSB + ADDR_W;
    localparam int PASS_LAT = 7;
    localparam int CAP_DLY  = 2;

    localparam logic [CODE_W-1:0] CODE_WR    = 6'b011111;
    localparam logic [CODE_W-1:0] CODE_RD    = 6'b011110;
    localparam logic [ADDR_W-1:0] COL_SENDER = '1;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_HEAD,
        ST_BODY
    } fsm_t;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_STORE,
        ACT_SERVE,
        ACT_RELAY
    } act_t;
endpackage

// File: rtl/xpn_frame_fsm.sv
module xpn_frame_fsm
    import xpn_pkg::*;
#(
    parameter int IDX_W = $clog2(WORD_W),
    parameter int SUB_W = $clog2(CFG_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              si,
    input  logic [ADDR_W-1:0] my_row,
    input  logic [ADDR_W-1:0] my_col,
    output logic              in_hunt,
    output logic              col_wr,
    output logic [ADDR_W-1:0] col_new,
    output logic              sub_en,
    output logic [SUB_W-1:0]  sub_idx,
    output logic              cap_pulse,
    output logic [CFG_W-1:0]  cap_cfg
);
    localparam int HDR_W = WORD_W - COL_LSB;

    fsm_t              state, state_n;
    act_t              act_q, act_n, act_dec;
    logic [IDX_W-1:0]  idx, idx_n;
    logic [WORD_W-2:0] sr;
    logic [HDR_W-1:0]  hdr;
    logic [CODE_W-1:0] hdr_code;
    logic [ADDR_W-1:0] hdr_row, hdr_col;
    logic              at_col, hit;

    // Header as seen on the edge that samples the last column bit
    assign hdr      = {sr[HDR_W-2:0], si};
    assign hdr_code = hdr[HDR_W-1 -: CODE_W];
    assign hdr_row  = hdr[2*ADDR_W-1 -: ADDR_W];
    assign hdr_col  = hdr[ADDR_W-1:0];
    assign at_col   = (state == ST_HEAD) && (idx == IDX_W'(COL_LSB));
    assign hit      = (hdr_row == my_row) && (hdr_col == my_col);

    always_comb begin
        if (hdr_code == CODE_RD)
            act_dec = hit ? ACT_SERVE : ACT_RELAY;
        else if ((hdr_code == CODE_WR) && hit)
            act_dec = ACT_STORE;
        else
            act_dec = ACT_NONE;
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        idx_n   = idx;
        act_n   = act_q;
        unique case (state)
            ST_HUNT: begin
                if (si) begin
                    state_n = ST_HEAD;
                    idx_n   = IDX_W'(WORD_W - 3);
                end
            end
            ST_HEAD: begin
                idx_n = idx - 1'b1;
                if (at_col) begin
                    state_n = ST_BODY;
                    act_n   = act_dec;
                end
            end
            ST_BODY: begin
                idx_n = idx - 1'b1;
                if (idx == '0) begin
                    state_n = ST_HUNT;
                    act_n   = ACT_NONE;
                end
            end
            default: begin
                state_n = ST_HUNT;
                act_n   = ACT_NONE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HUNT;
            idx   <= '0;
            act_q <= ACT_NONE;
            sr    <= '0;
        end else begin
            state <= state_n;
            idx   <= idx_n;
            act_q <= act_n;
            sr    <= {sr[WORD_W-3:0], si};
        end
    end

    // Outputs
    always_comb begin
        in_hunt   = (state == ST_HUNT);
        col_wr    = at_col && (hdr_code == CODE_RD);
        col_new   = hit ? COL_SENDER : (hdr_col - 1'b1);
        sub_en    = (state == ST_BODY) && (act_q == ACT_SERVE);
        sub_idx   = idx[SUB_W-1:0];
        cap_pulse = (state == ST_BODY) && (idx == '0) && (act_q == ACT_STORE);
        cap_cfg   = {sr[CFG_W-2:0], si};
    end

    // R1: a 1 seen while hunting always opens a header
    a_r1_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT) && si |=> (state == ST_HEAD));

    // R1: the body phase only walks select-bit positions
    a_r1_body_span: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BODY) |-> (idx < IDX_W'(COL_LSB)));
endmodule

// File: rtl/xpn_pass_line.sv
module xpn_pass_line #(
    parameter int LAT  = 7,
    parameter int COLW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            si,
    input  logic            sub_en,
    input  logic            sub_bit,
    input  logic            col_wr,
    input  logic [COLW-1:0] col_new,
    output logic            line_out
);
    logic [LAT-1:0] dl;
    logic           in_bit;

    assign in_bit   = sub_en ? sub_bit : si;
    assign line_out = dl[LAT-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dl <= '0;
        end else begin
            dl <= {dl[LAT-2:0], in_bit};
            // Rewrite the column bits that have just entered the line
            if (col_wr)
                dl[COLW-1:0] <= col_new;
        end
    end
endmodule

// File: rtl/xpn_cfg_bank.sv
module xpn_cfg_bank #(
    parameter int W   = 12,
    parameter int DLY = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_pulse,
    input  logic [W-1:0] cap_cfg,
    input  logic         load,
    output logic [W-1:0] active
);
    logic         pv [DLY];
    logic [W-1:0] pd [DLY];
    logic [W-1:0] staged;
    logic         pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DLY; k++) begin
                pv[k] <= 1'b0;
                pd[k] <= '0;
            end
            staged <= '0;
            pend   <= 1'b0;
            active <= '0;
        end else begin
            pv[0] <= cap_pulse;
            pd[0] <= cap_cfg;
            for (int k = 1; k < DLY; k++) begin
                pv[k] <= pv[k-1];
                pd[k] <= pd[k-1];
            end
            if (pv[DLY-1]) begin
                staged <= pd[DLY-1];
                pend   <= 1'b1;
            end else if (load && pend) begin
                pend <= 1'b0;
            end
            if (load && pend)
                active <= staged;
        end
    end

    // R3: a word leaving the staging pipeline is always pending next cycle
    a_r3_stage_lands: assert property (@(posedge clk) disable iff (!rst_n)
        pv[DLY-1] |=> pend);

    // R5: strobe with nothing pending never moves the configuration
    a_r5_idle_load: assert property (@(posedge clk) disable iff (!rst_n)
        load && !pend |=> $stable(active));

    // R4: a commit uses up the pending word unless a new one lands
    a_r4_consume: assert property (@(posedge clk) disable iff (!rst_n)
        load && pend && !pv[DLY-1] |=> !pend);
endmodule

// File: rtl/xpn_node.sv
module xpn_node
    import xpn_pkg::*;
(
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              si,
    input  logic              load,
    input  logic [ADDR_W-1:0] my_row,
    input  logic [ADDR_W-1:0] my_col,
    output logic              rso,
    output logic              cso,
    output logic              sclk_fwd,
    output logic [CFG_W-1:0]  cfg_sel
);
    localparam int SUB_W = $clog2(CFG_W);

    logic              in_hunt, col_wr, sub_en, cap_pulse, line_out;
    logic [ADDR_W-1:0] col_new;
    logic [SUB_W-1:0]  sub_idx;
    logic [CFG_W-1:0]  cap_cfg;

    xpn_frame_fsm u_fsm (
        .clk      (sclk),
        .rst_n    (rst_n),
        .si       (si),
        .my_row   (my_row),
        .my_col   (my_col),
        .in_hunt  (in_hunt),
        .col_wr   (col_wr),
        .col_new  (col_new),
        .sub_en   (sub_en),
        .sub_idx  (sub_idx),
        .cap_pulse(cap_pulse),
        .cap_cfg  (cap_cfg)
    );

    xpn_pass_line #(.LAT(PASS_LAT), .COLW(ADDR_W)) u_line (
        .clk     (sclk),
        .rst_n   (rst_n),
        .si      (si),
        .sub_en  (sub_en),
        .sub_bit (cfg_sel[sub_idx]),
        .col_wr  (col_wr),
        .col_new (col_new),
        .line_out(line_out)
    );

    xpn_cfg_bank #(.W(CFG_W), .DLY(CAP_DLY)) u_bank (
        .clk      (sclk),
        .rst_n    (rst_n),
        .cap_pulse(cap_pulse),
        .cap_cfg  (cap_cfg),
        .load     (load),
        .active   (cfg_sel)
    );

    assign rso      = line_out;
    assign cso      = line_out;
    assign sclk_fwd = sclk;

    // Edge count since reset, saturating, guards the latency check
    logic [3:0] up_cnt;
    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n)
            up_cnt <= '0;
        else if (up_cnt != 4'd9)
            up_cnt <= up_cnt + 1'b1;
    end

    generate
        if (PASS_LAT == 7) begin : g_lat_chk
            // R2: bits taken in while hunting leave unmodified 7 edges later
            a_r2_latency: assert property (@(posedge sclk) disable iff (!rst_n)
                (up_cnt == 4'd9) && $past(in_hunt, 7) |-> (rso == $past(si, 7)));
        end
    endgenerate
endmodule

// File: tb/xpn_node_bench.sv
module xpn_node_bench;
    localparam logic [5:0] WR = 6'b011111;
    localparam logic [5:0] RD = 6'b011110;
    localparam int NV = 8;
    localparam int VW = 30 + 30 + 1 + 12;

    // {input word, expected forwarded word, load strobe, expected cfg_sel}
    // node sits at row 2, column 5
    localparam logic [VW-1:0] VEC [NV] = '{
        {WR, 6'd2, 6'd5, 12'h29C,   WR, 6'd2, 6'd5, 12'h29C,   1'b1, 12'h29C},
        {WR, 6'd3, 6'd5, 12'hFFF,   WR, 6'd3, 6'd5, 12'hFFF,   1'b1, 12'h29C},
        {RD, 6'd2, 6'd5, 12'h000,   RD, 6'd2, 6'h3F, 12'h29C,  1'b0, 12'h29C},
        {RD, 6'd0, 6'h3F, 12'h123,  RD, 6'd0, 6'h3E, 12'h123,  1'b0, 12'h29C},
        {RD, 6'd0, 6'd0, 12'h456,   RD, 6'd0, 6'h3F, 12'h456,  1'b0, 12'h29C},
        {RD, 6'd7, 6'd5, 12'h000,   RD, 6'd7, 6'd4, 12'h000,   1'b0, 12'h29C},
        {6'b010101, 6'd2, 6'd5, 12'h0F0, 6'b010101, 6'd2, 6'd5, 12'h0F0, 1'b1, 12'h29C},
        {WR, 6'd2, 6'd5, 12'h6B1,   WR, 6'd2, 6'd5, 12'h6B1,   1'b1, 12'h6B1}
    };

    logic        sclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        si = 1'b0;
    logic        load = 1'b0;
    logic [5:0]  my_row = 6'd2;
    logic [5:0]  my_col = 6'd5;
    logic        rso, cso, sclk_fwd;
    logic [11:0] cfg_sel;

    int          checks = 0;
    int          errors = 0;
    int          cso_bad = 0;
    logic [63:0] hist = '0;
    bit          done = 1'b0;

    always #2 sclk = ~sclk;

    xpn_node u_xpn_node (
        .sclk    (sclk),
        .rst_n   (rst_n),
        .si      (si),
        .load    (load),
        .my_row  (my_row),
        .my_col  (my_col),
        .rso     (rso),
        .cso     (cso),
        .sclk_fwd(sclk_fwd),
        .cfg_sel (cfg_sel)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic b, input logic l);
        @(negedge sclk);
        hist = {hist[62:0], rso};
        if (cso !== rso) cso_bad++;
        si   = b;
        load = l;
    endtask

    task automatic send_word(input logic [29:0] w);
        for (int i = 29; i >= 0; i--) tick(w[i], 1'b0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge sclk);
        rst_n = 1'b1;
        // R10: reset state
        check("R10 cfg", 32'(cfg_sel), 32'h000);
        check("R10 rso", 32'(rso), 32'h0);
        check("R10 cso", 32'(cso), 32'h0);
        // R11: forwarded clock at both phases
        check("R11 low", 32'(sclk_fwd), 32'(sclk));
        @(posedge sclk); #1;
        check("R11 high", 32'(sclk_fwd), 32'(sclk));

        // R5: strobe with nothing captured
        tick(1'b0, 1'b1);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        check("R5 load without capture", 32'(cfg_sel), 32'h000);

        // Table walk: R1 R2 R4 R6 R7 R8 R9
        for (int v = 0; v < NV; v++) begin
            logic [29:0] w_in, w_out;
            logic        ld;
            logic [11:0] c_exp;
            {w_in, w_out, ld, c_exp} = VEC[v];
            send_word(w_in);
            repeat (7) tick(1'b0, 1'b0);
            check($sformatf("R1 R2 R6 R7 R8 stream vec %0d", v), 32'(hist[29:0]), 32'(w_out));
            tick(1'b0, ld);
            tick(1'b0, 1'b0);
            tick(1'b0, 1'b0);
            check($sformatf("R4 R5 R6 R9 cfg vec %0d", v), 32'(cfg_sel), 32'(c_exp));
        end

        // R3: commit becomes possible only on the third edge after the last bit
        send_word({WR, 6'd2, 6'd5, 12'h111});
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b1);
        tick(1'b0, 1'b1);
        check("R3 early strobe ignored", 32'(cfg_sel), 32'h6B1);
        tick(1'b0, 1'b0);
        check("R3 commit on third edge", 32'(cfg_sel), 32'h111);

        // R5: second strobe after the commit has nothing pending
        tick(1'b0, 1'b1);
        tick(1'b0, 1'b0);
        check("R5 repeat strobe", 32'(cfg_sel), 32'h111);

        // R2: cso mirrored rso on every sampled cycle
        check("R2 cso mirrors rso", 32'(cso_bad), 32'd0);
        finish_run();
    end
endmodule